// File: doc/BRIEF.md
# Dual-Port Burst-Addressed Synchronous RAM

This block is a synchronous memory with two fully independent access ports. Both ports share one clock. In any cycle either port may read or write any word, and both ports may address the same word in the same cycle. Each word is split into two byte lanes, and each lane has its own write enable. With the default parameters the memory holds 1K words of 18 bits. Setting `ADDR_W` to 13 gives an 8K-word organisation.

Each port has its own address counter, so a burst can run without a new address being presented. In every cycle the counter can be cleared, loaded from the external address, advanced by one, or left unchanged. The address used for the access in that cycle is the counter's new value. A clear therefore costs no dead cycle, and the access in that cycle goes to word 0.

A per-port mode bit sets the read latency:

- **Flow-through:** read data appears one clock after the address.
- **Pipelined:** read data passes through an extra output register and appears two clocks after the address.

A valid flag goes with the read data on each port.

Top module: `burst_dpram`

## Requirements
- R1: Both ports access the memory independently in the same cycle. Each port can read or write any word, and both may use the same word at once.
- R2: With the port's `pipe_sel` bit at 0, read data and the valid flag appear on the outputs after the first rising edge that follows the access cycle.
- R3: With the port's `pipe_sel` bit at 1, read data and the valid flag appear one clock later than in R2.
- R4: With `load_n` low and `zero_n` high, the access uses the external address, and the counter takes that value.
- R5: With `zero_n` and `load_n` high and `step_n` low, the access uses the previous counter value plus one. The count wraps from 2^ADDR_W-1 to 0.
- R6: With `zero_n`, `load_n` and `step_n` all high, the counter keeps its value, and the access reuses that address.
- R7: With `zero_n` low, the access uses word 0 and the counter becomes 0. This takes priority over load and step, and a read or write may happen in the same cycle.
- R8: `lane_we` bit 0 covers data bits [8:0] and bit 1 covers data bits [17:9]. A write changes only the enabled lanes.
- R9: If one port writes a word while the other port reads it in the same cycle, the read returns the old contents. The new data is visible from the next cycle on.
- R10: A port's valid flag is high only for cycles with `sel_n` low, `oe_n` low and no lane write enable set. While `sel_n` is high the port writes nothing.
- R11: If both ports write the same lane of the same word in one cycle, the value from port A is stored.
- R12: Synchronous active-high `rst` clears both valid flags and both counters. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| pipe_sel | input | 2 | Per-port read latency mode; bit 0 is port A, bit 1 is port B; 1 selects pipelined |
| a_sel_n | input | 1 | Port A select, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_lane_we | input | LANES | Port A byte-lane write enables |
| a_zero_n | input | 1 | Port A counter clear, active low |
| a_load_n | input | 1 | Port A address load strobe, active low |
| a_step_n | input | 1 | Port A counter advance enable, active low |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | LANE_W*LANES | Port A write data |
| a_rdata | output | LANE_W*LANES | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| b_sel_n | input | 1 | Port B select, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_lane_we | input | LANES | Port B byte-lane write enables |
| b_zero_n | input | 1 | Port B counter clear, active low |
| b_load_n | input | 1 | Port B address load strobe, active low |
| b_step_n | input | 1 | Port B counter advance enable, active low |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | LANE_W*LANES | Port B write data |
| b_rdata | output | LANE_W*LANES | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
The assertions check the counter on every cycle: the priority of clear, then load, then step, then hold, the wrap of the increment, and the suppression of the valid flag in both latency modes. The stored data cannot be seen by a property, so the bench's scenarios must show it. This covers byte-lane masking, old data returned on a same-cycle read and write, port A winning a double write, and deselected writes leaving the memory unchanged. The bench also shows that the data arrives in the cycle each mode promises.

// File: rtl/burst_dpram_pkg.sv
package burst_dpram_pkg;

    typedef enum logic [1:0] {
        CTR_ZERO = 2'd0,
        CTR_LOAD = 2'd1,
        CTR_STEP = 2'd2,
        CTR_HOLD = 2'd3
    } ctr_op_e;

    typedef enum logic {
        LAT_FLOW = 1'b0,
        LAT_PIPE = 1'b1
    } lat_mode_e;

    localparam int NUM_PORTS = 2;

    // Clear outranks load, load outranks step.
    function automatic ctr_op_e decode_ctr(input logic zero_n, input logic load_n,
                                           input logic step_n);
        if (!zero_n)      return CTR_ZERO;
        else if (!load_n) return CTR_LOAD;
        else if (!step_n) return CTR_STEP;
        else              return CTR_HOLD;
    endfunction

endpackage

// File: rtl/burst_dpram_ctr.sv
module burst_dpram_ctr
    import burst_dpram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              zero_n,
    input  logic              load_n,
    input  logic              step_n,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    logic [ADDR_W-1:0] cnt_q;
    ctr_op_e           op;

    assign op = decode_ctr(zero_n, load_n, step_n);

    always_comb begin
        unique case (op)
            CTR_ZERO: acc_addr = '0;
            CTR_LOAD: acc_addr = ext_addr;
            CTR_STEP: acc_addr = cnt_q + ADDR_W'(1);
            default:  acc_addr = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= acc_addr;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        !zero_n |=> cnt_q == '0);                                              // R7
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        zero_n && !load_n |=> cnt_q == $past(ext_addr));                       // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        zero_n && load_n && !step_n |=> cnt_q == ADDR_W'($past(cnt_q) + 1'b1)); // R5
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
        zero_n && load_n && step_n |=> $stable(cnt_q));                        // R6

endmodule

// File: rtl/burst_dpram_lane.sv
module burst_dpram_lane #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [LANE_W-1:0] din_a,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [LANE_W-1:0] din_b,
    output logic [LANE_W-1:0] q_a,
    output logic [LANE_W-1:0] q_b
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    // Reads see pre-write contents; port A's write is issued last and wins.
    always_ff @(posedge clk) begin
        q_a <= mem[addr_a];
        q_b <= mem[addr_b];
        if (we_b) mem[addr_b] <= din_b;
        if (we_a) mem[addr_a] <= din_a;
    end

endmodule

// File: rtl/burst_dpram_rdpath.sv
module burst_dpram_rdpath
    import burst_dpram_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              pipe,
    input  logic [DATA_W-1:0] ram_q,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid
);

    logic              ft_v_q;
    logic              pp_v_q;
    logic [DATA_W-1:0] pp_d_q;
    lat_mode_e         mode;

    assign mode = lat_mode_e'(pipe);

    always_ff @(posedge clk) begin
        if (rst) begin
            ft_v_q <= 1'b0;
            pp_v_q <= 1'b0;
        end else begin
            ft_v_q <= rd_req;
            pp_v_q <= ft_v_q;
        end
        pp_d_q <= ram_q;
    end

    assign dout   = (mode == LAT_PIPE) ? pp_d_q : ram_q;
    assign dvalid = (mode == LAT_PIPE) ? pp_v_q : ft_v_q;

    AST_FLOW_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd_req && !pipe |=> pipe || !dvalid);                                 // R10
    AST_PIPE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> ##1 (!pipe || !dvalid));                                   // R10

endmodule

// File: rtl/burst_dpram.sv
module burst_dpram
    import burst_dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                pipe_sel,
    input  logic                      a_sel_n,
    input  logic                      a_oe_n,
    input  logic [LANES-1:0]          a_lane_we,
    input  logic                      a_zero_n,
    input  logic                      a_load_n,
    input  logic                      a_step_n,
    input  logic [ADDR_W-1:0]         a_addr,
    input  logic [LANE_W*LANES-1:0]   a_wdata,
    output logic [LANE_W*LANES-1:0]   a_rdata,
    output logic                      a_rvalid,
    input  logic                      b_sel_n,
    input  logic                      b_oe_n,
    input  logic [LANES-1:0]          b_lane_we,
    input  logic                      b_zero_n,
    input  logic                      b_load_n,
    input  logic                      b_step_n,
    input  logic [ADDR_W-1:0]         b_addr,
    input  logic [LANE_W*LANES-1:0]   b_wdata,
    output logic [LANE_W*LANES-1:0]   b_rdata,
    output logic                      b_rvalid
);

    localparam int DATA_W = LANE_W * LANES;
    localparam int NP     = NUM_PORTS;

    logic [NP-1:0]             sel_n, oe_n, zero_n, load_n, step_n, rd_req, dvalid;
    logic [NP-1:0][LANES-1:0]  lane_we, wr_lane;
    logic [NP-1:0][ADDR_W-1:0] ext_addr, acc_addr;
    logic [NP-1:0][DATA_W-1:0] wdata, ram_q, dout;

    assign sel_n    = {b_sel_n, a_sel_n};
    assign oe_n     = {b_oe_n, a_oe_n};
    assign zero_n   = {b_zero_n, a_zero_n};
    assign load_n   = {b_load_n, a_load_n};
    assign step_n   = {b_step_n, a_step_n};
    assign lane_we  = {b_lane_we, a_lane_we};
    assign ext_addr = {b_addr, a_addr};
    assign wdata    = {b_wdata, a_wdata};

    for (genvar p = 0; p < NP; p++) begin : g_port
        assign wr_lane[p] = sel_n[p] ? '0 : lane_we[p];
        assign rd_req[p]  = !sel_n[p] && !oe_n[p] && (lane_we[p] == '0);

        burst_dpram_ctr #(.ADDR_W(ADDR_W)) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .zero_n   (zero_n[p]),
            .load_n   (load_n[p]),
            .step_n   (step_n[p]),
            .ext_addr (ext_addr[p]),
            .acc_addr (acc_addr[p])
        );

        burst_dpram_rdpath #(.DATA_W(DATA_W)) u_rd (
            .clk    (clk),
            .rst    (rst),
            .rd_req (rd_req[p]),
            .pipe   (pipe_sel[p]),
            .ram_q  (ram_q[p]),
            .dout   (dout[p]),
            .dvalid (dvalid[p])
        );
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        burst_dpram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk    (clk),
            .we_a   (wr_lane[0][l]),
            .addr_a (acc_addr[0]),
            .din_a  (wdata[0][l*LANE_W +: LANE_W]),
            .we_b   (wr_lane[1][l]),
            .addr_b (acc_addr[1]),
            .din_b  (wdata[1][l*LANE_W +: LANE_W]),
            .q_a    (ram_q[0][l*LANE_W +: LANE_W]),
            .q_b    (ram_q[1][l*LANE_W +: LANE_W])
        );
    end

    assign a_rdata  = dout[0];
    assign b_rdata  = dout[1];
    assign a_rvalid = dvalid[0];
    assign b_rvalid = dvalid[1];

endmodule

// File: tb/sim_burst_dpram.sv
module sim_burst_dpram;

    localparam int PERIOD = 10;
    localparam int AW     = 10;
    localparam int LW     = 9;
    localparam int DW     = 18;
    localparam int DEPTH  = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] pipe = 2'b00;
    logic [1:0] sel_n, oe_n, zero_n, load_n, step_n;
    logic [1:0][1:0]    lwe;
    logic [1:0][AW-1:0] addr;
    logic [1:0][DW-1:0] wd;
    logic [1:0]         rv;
    logic [1:0][DW-1:0] rd;

    int checks = 0;
    int fails  = 0;
    string cur_tag = "R1";

    logic [DW-1:0] mdl [DEPTH];
    int            mcnt [2];
    logic          ftv [2], ppv [2];
    logic [DW-1:0] ftd [2], ppd [2];

    always #(PERIOD/2) clk = ~clk;

    burst_dpram u0 (
        .clk(clk), .rst(rst), .pipe_sel(pipe),
        .a_sel_n(sel_n[0]), .a_oe_n(oe_n[0]), .a_lane_we(lwe[0]), .a_zero_n(zero_n[0]),
        .a_load_n(load_n[0]), .a_step_n(step_n[0]), .a_addr(addr[0]), .a_wdata(wd[0]),
        .a_rdata(rd[0]), .a_rvalid(rv[0]),
        .b_sel_n(sel_n[1]), .b_oe_n(oe_n[1]), .b_lane_we(lwe[1]), .b_zero_n(zero_n[1]),
        .b_load_n(load_n[1]), .b_step_n(step_n[1]), .b_addr(addr[1]), .b_wdata(wd[1]),
        .b_rdata(rd[1]), .b_rvalid(rv[1])
    );

    task automatic chk(string tag, int p, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s port%0d t=%0t actual=%h expected=%h", tag, p, $time, act, exp);
        end
    endtask

    task automatic drv(int p, logic s_n, logic o_n, logic [1:0] we, logic z_n,
                       logic l_n, logic st_n, logic [AW-1:0] a, logic [DW-1:0] d);
        sel_n[p] = s_n; oe_n[p] = o_n; lwe[p] = we; zero_n[p] = z_n;
        load_n[p] = l_n; step_n[p] = st_n; addr[p] = a; wd[p] = d;
    endtask

    task automatic idle(int p);
        drv(p, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    // Reference: access address is the counter's new value, reads see old data,
    // port A's write is applied last.
    task automatic cycle();
        int ea [2];
        logic [DW-1:0] rdv [2];
        logic rq [2];
        logic expv;
        logic [DW-1:0] expd;
        for (int p = 0; p < 2; p++) begin
            if (!zero_n[p])      ea[p] = 0;
            else if (!load_n[p]) ea[p] = int'(addr[p]);
            else if (!step_n[p]) ea[p] = (mcnt[p] + 1) % DEPTH;
            else                 ea[p] = mcnt[p];
            mcnt[p] = ea[p];
            rdv[p]  = mdl[ea[p]];
            rq[p]   = !sel_n[p] && !oe_n[p] && (lwe[p] == 2'b00);
        end
        for (int p = 1; p >= 0; p--)
            if (!sel_n[p])
                for (int l = 0; l < 2; l++)
                    if (lwe[p][l]) mdl[ea[p]][l*LW +: LW] = wd[p][l*LW +: LW];
        for (int p = 0; p < 2; p++) begin
            ppv[p] = ftv[p]; ppd[p] = ftd[p];
            ftv[p] = rq[p];  ftd[p] = rdv[p];
        end
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            expv = pipe[p] ? ppv[p] : ftv[p];
            expd = pipe[p] ? ppd[p] : ftd[p];
            chk(cur_tag, p, 32'(rv[p]), 32'(expv));
            if (expv) chk(cur_tag, p, 32'(rd[p]), 32'(expd));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(0); idle(1);
        @(posedge clk);
        @(negedge clk);
        chk("R12", 0, 32'(rv[0]), 32'd0);
        chk("R12", 1, 32'(rv[1]), 32'd0);
        for (int p = 0; p < 2; p++) begin
            mcnt[p] = 0; ftv[p] = 1'b0; ppv[p] = 1'b0;
        end
        rst = 1'b0;
    endtask

    task automatic rnd(int n, string tag);
        cur_tag = tag;
        for (int i = 0; i < n; i++) begin
            for (int p = 0; p < 2; p++) begin
                logic [AW-1:0] a;
                a = ($urandom % 2 == 0) ? AW'($urandom % 16) : AW'($urandom);
                drv(p, ($urandom % 8) == 0, ($urandom % 8) == 0,
                    (($urandom % 4) == 0) ? 2'($urandom) : 2'b00,
                    ($urandom % 16) != 0, ($urandom % 4) != 0, ($urandom % 2) != 0,
                    a, DW'($urandom));
            end
            cycle();
        end
        idle(0); idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired t=%0t actual=running expected=done", $time);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        idle(0); idle(1);
        do_reset();

        // Fill all words through port A as a burst (R5 stepping, R4 load).
        cur_tag = "R1";
        drv(0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 1'b1, '0, DW'(18'h15A5A));
        cycle();
        for (int i = 1; i < DEPTH; i++) begin
            drv(0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b1, 1'b0, '0, DW'(i * 37 + 5));
            cycle();
        end
        idle(0);

        // R12: counter cleared by reset; a hold read goes to word 0.
        do_reset();
        cur_tag = "R12";
        drv(0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, '0, '0);
        cycle(); idle(0); cycle(); cycle();

        // R2: flow-through read on both ports of the same word.
        cur_tag = "R2";
        drv(0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, AW'(5), '0);
        drv(1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, AW'(5), '0);
        cycle(); idle(0); idle(1); cycle();

        // R4 then R6: load an address, then hold.
        cur_tag = "R4";
        drv(0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, AW'(100), '0);
        cycle();
        cur_tag = "R6";
        drv(0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, AW'(3), '0);
        repeat (3) cycle();
        idle(0); cycle();

        // R5: increment wraps past the top word.
        cur_tag = "R5";
        drv(0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, AW'(DEPTH - 2), '0);
        cycle();
        drv(0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, '0, '0);
        repeat (3) cycle();
        idle(0); cycle();

        // R7: clear beats load; a write goes to word 0 in the same cycle.
        cur_tag = "R7";
        drv(0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, AW'(77), '0);
        cycle();
        drv(0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1, AW'(88), DW'(18'h2BEEF));
        cycle();
        drv(0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, AW'(0), '0);
        cycle();
        drv(0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, AW'(88), '0);
        cycle(); idle(0); cycle();

        // R8: upper lane only.
        cur_tag = "R8";
        drv(0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1, AW'(200), DW'(18'h3FFFF));
        cycle();
        drv(0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, '0, '0);
        cycle(); idle(0); cycle();

        // R9: A writes while B reads the same word.
        cur_tag = "R9";
        drv(0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 1'b1, AW'(300), DW'(18'h12345));
        drv(1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, AW'(300), '0);
        cycle(); idle(0);
        drv(1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, '0, '0);
        cycle(); idle(1); cycle();

        // R11: both ports write the same word.
        cur_tag = "R11";
        drv(0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 1'b1, AW'(400), DW'(18'h0AAAA));
        drv(1, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 1'b1, AW'(400), DW'(18'h35555));
        cycle();
        drv(0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, '0, '0);
        idle(1);
        cycle(); idle(0); cycle();

        // R10: deselected write is dropped; oe high hides the read.
        cur_tag = "R10";
        drv(1, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0, 1'b1, AW'(500), DW'(18'h00000));
        drv(0, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, AW'(500), '0);
        cycle(); idle(1);
        drv(0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, '0, '0);
        cycle(); idle(0); cycle();

        // R3: pipelined latency, then mixed modes, then flow-through.
        pipe = 2'b11;
        cycle(); cycle();
        rnd(2000, "R3");
        pipe = 2'b01;
        cycle(); cycle();
        rnd(2000, "R1");
        pipe = 2'b00;
        cycle(); cycle();
        rnd(2000, "R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule